// File: doc/BRIEF.md
# Fixed-Point to Integer Rounding Converter

This block takes a sign bit and an unsigned fixed-point magnitude, rounds the magnitude to an integer under one of four IEEE rounding modes, and returns a signed 32-bit two's-complement integer. The magnitude is 64 bits wide with seven fraction bits at the bottom, and its top bit is always zero. Each result comes with three flags. Invalid means the value does not fit, and the result is then the integer-indefinite pattern. Inexact means fraction bits were discarded. Rounded-up means the rounded magnitude is larger than the exact input.

The datapath does its work in a single combinational stage followed by one output register. Operands arrive on a valid/ready stream and results leave on another. An operand is accepted on a clock edge where `in_valid` and `in_ready` are both high. Its result is presented with `out_valid` from the following cycle. `in_ready` is high whenever the output register is empty or is being drained in the same cycle (`out_ready` high). While `out_valid` is high and `out_ready` is low, the result and its flags stay frozen and no new operand is taken. There is no other buffering.

Top module: `fxr_to_int_rnd`

## Requirements
- R1: The rounding mode is selected by `in_mode`: 2'b00 = nearest-even, 2'b01 = toward minus infinity, 2'b10 = toward plus infinity, 2'b11 = toward zero. A directed mode rounds the magnitude away from zero only when its direction matches the sign. Toward zero never increments.
- R2: In nearest-even mode, a fraction field (bits 6:0) of exactly 7'h40 rounds to the even neighbour. A larger fraction rounds the magnitude up and a smaller one truncates.
- R3: A positive result above 2^31-1, or a negative result below -2^31, sets `out_invalid` and returns 32'h80000000.
- R4: With `in_sign` high, the result is the two's-complement negation of the rounded magnitude. A negative value whose rounded magnitude is exactly 2^31 returns 32'h80000000 with `out_invalid` low.
- R5: `out_inexact` is high exactly when bits 6:0 of the magnitude are nonzero and `out_invalid` is low.
- R6: `out_rndup` is high exactly when the rounded magnitude is greater than the exact magnitude and `out_invalid` is low. It is never high without `out_inexact`.
- R7: While `out_valid` is high and `out_ready` is low, `in_ready` is low and all outputs keep their values.
- R8: An accepted operand produces `out_valid` on the next clock edge. After reset, `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operand present |
| in_ready | output | 1 | Block can accept an operand this cycle |
| in_sign | input | 1 | Sign of the operand, 1 = negative |
| in_mag | input | 64 | Unsigned magnitude, seven fraction bits, top bit zero |
| in_mode | input | 2 | Rounding mode, encoded as in R1 |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result this cycle |
| out_int | output | 32 | Rounded signed integer |
| out_invalid | output | 1 | Result out of range; `out_int` is the indefinite pattern |
| out_inexact | output | 1 | Fraction bits were discarded |
| out_rndup | output | 1 | Rounded magnitude exceeds the exact magnitude |

## Verification
The hardest cases sit right at the 32-bit boundary, where the rounding carry alone decides between a legal result and an invalid one. Examples are a negative magnitude just under 2^31 that a directed mode pushes to exactly 2^31, which is legal, and the same push on a positive value, which is not. Random operands almost never land there. The stimulus therefore places magnitudes of the form 2^31 or 2^31-1 with hand-picked fraction bits under every mode and both signs. After that, random operands with widths drawn from several ranges run under random back-pressure.

// File: rtl/fxr_pkg.sv
package fxr_pkg;
  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_DOWN = 2'b01,
    RM_UP   = 2'b10,
    RM_ZERO = 2'b11
  } rmode_e;
endpackage

// File: rtl/fxr_incr_sel.sv
module fxr_incr_sel #(
  parameter int FRAC_W = 7
) (
  input  logic [1:0]        mode,
  input  logic              sign,
  output logic [FRAC_W-1:0] incr,
  output logic              nearest
);
  import fxr_pkg::*;
  localparam logic [FRAC_W-1:0] HALF = {1'b1, {(FRAC_W-1){1'b0}}};
  localparam logic [FRAC_W-1:0] ALL1 = {FRAC_W{1'b1}};

  rmode_e rm;
  assign rm = rmode_e'(mode);

  always_comb begin
    nearest = 1'b0;
    unique case (rm)
      RM_NEAR: begin incr = HALF; nearest = 1'b1; end
      RM_DOWN: incr = sign ? ALL1 : '0;
      RM_UP:   incr = sign ? '0 : ALL1;
      default: incr = '0;
    endcase
  end
endmodule

// File: rtl/fxr_round_core.sv
module fxr_round_core #(
  parameter int MAG_W  = 64,
  parameter int FRAC_W = 7,
  localparam int RND_W = MAG_W - FRAC_W
) (
  input  logic [MAG_W-1:0]  exact,
  input  logic [FRAC_W-1:0] incr,
  input  logic              nearest,
  output logic [RND_W-1:0]  mag_rnd,
  output logic              frac_nz,
  output logic              grew
);
  localparam logic [FRAC_W-1:0] HALF = {1'b1, {(FRAC_W-1){1'b0}}};

  logic [MAG_W-1:0]  sum;
  logic [FRAC_W-1:0] frac;
  logic [RND_W-1:0]  shifted;
  logic              tie;

  assign frac    = exact[FRAC_W-1:0];
  assign sum     = exact + {{(MAG_W-FRAC_W){1'b0}}, incr};
  assign shifted = sum[MAG_W-1:FRAC_W];
  assign tie     = nearest && (frac == HALF);
  assign frac_nz = |frac;

  always_comb begin
    mag_rnd    = shifted;
    mag_rnd[0] = shifted[0] & ~tie;
  end

  assign grew = {mag_rnd, {FRAC_W{1'b0}}} > exact;
endmodule

// File: rtl/fxr_range_chk.sv
module fxr_range_chk #(
  parameter int RND_W = 57,
  parameter int INT_W = 32
) (
  input  logic [RND_W-1:0] mag_rnd,
  input  logic             sign,
  output logic [INT_W-1:0] z,
  output logic             bad
);
  logic [INT_W-1:0] low;
  logic             high;

  assign low  = mag_rnd[INT_W-1:0];
  assign high = |mag_rnd[RND_W-1:INT_W];
  assign z    = sign ? (~low + 1'b1) : low;
  assign bad  = high || ((z != '0) && (z[INT_W-1] ^ sign));
endmodule

// File: rtl/fxr_to_int_rnd.sv
module fxr_to_int_rnd #(
  parameter int MAG_W  = 64,
  parameter int FRAC_W = 7,
  parameter int INT_W  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_sign,
  input  logic [63:0]      in_mag,
  input  logic [1:0]       in_mode,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [31:0]      out_int,
  output logic             out_invalid,
  output logic             out_inexact,
  output logic             out_rndup
);
  import fxr_pkg::*;
  localparam int RND_W = MAG_W - FRAC_W;
  localparam logic [INT_W-1:0] INDEF = {1'b1, {(INT_W-1){1'b0}}};

  logic [FRAC_W-1:0] incr;
  logic              nearest;
  logic [RND_W-1:0]  mag_rnd;
  logic              frac_nz, grew;
  logic [INT_W-1:0]  z;
  logic              bad;
  logic              take;

  fxr_incr_sel #(.FRAC_W(FRAC_W)) u_sel (
    .mode(in_mode), .sign(in_sign), .incr(incr), .nearest(nearest)
  );

  fxr_round_core #(.MAG_W(MAG_W), .FRAC_W(FRAC_W)) u_core (
    .exact(in_mag), .incr(incr), .nearest(nearest),
    .mag_rnd(mag_rnd), .frac_nz(frac_nz), .grew(grew)
  );

  fxr_range_chk #(.RND_W(RND_W), .INT_W(INT_W)) u_chk (
    .mag_rnd(mag_rnd), .sign(in_sign), .z(z), .bad(bad)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_int     <= '0;
      out_invalid <= 1'b0;
      out_inexact <= 1'b0;
      out_rndup   <= 1'b0;
    end else if (take) begin
      out_valid   <= 1'b1;
      out_int     <= bad ? INDEF : z;
      out_invalid <= bad;
      out_inexact <= !bad && frac_nz;
      out_rndup   <= !bad && frac_nz && grew;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_int) && $stable(out_invalid)
      && $stable(out_inexact) && $stable(out_rndup));

  p_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  p_indef_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_invalid |-> out_int == INDEF && !out_inexact && !out_rndup);

  p_up_needs_inexact_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_rndup |-> out_inexact);

  p_zero_mode_no_up_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_mode == 2'b11 |=> !out_rndup);
endmodule

// File: tb/tb_fxr_to_int_rnd.sv
`timescale 1ns/1ps
module tb_fxr_to_int_rnd;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_sign = 1'b0;
  logic [63:0] in_mag = '0;
  logic [1:0]  in_mode = 2'b00;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_int;
  logic        out_invalid, out_inexact, out_rndup;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit bp_on = 1'b0;
  bit done = 1'b0;

  typedef struct packed {
    logic        inv;
    logic        inx;
    logic        rup;
    logic [31:0] res;
    logic        tie;
    logic        sgn;
  } exp_t;
  exp_t q[$];

  always #2 clk = ~clk;

  fxr_to_int_rnd dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sign(in_sign), .in_mag(in_mag), .in_mode(in_mode),
    .out_valid(out_valid), .out_ready(out_ready), .out_int(out_int),
    .out_invalid(out_invalid), .out_inexact(out_inexact), .out_rndup(out_rndup)
  );

  function automatic exp_t model(input logic s, input logic [63:0] m, input logic [1:0] md);
    exp_t e;
    logic [6:0]  fr;
    logic [63:0] ip, rnd;
    bit up;
    fr = m[6:0];
    ip = m >> 7;
    up = 1'b0;
    case (md)
      2'b00: up = (fr > 7'h40) || (fr == 7'h40 && ip[0]);
      2'b01: up = s && (fr != 0);
      2'b10: up = !s && (fr != 0);
      default: up = 1'b0;
    endcase
    rnd = ip + (up ? 64'd1 : 64'd0);
    e.inv = s ? (rnd > 64'h8000_0000) : (rnd > 64'h7FFF_FFFF);
    e.inx = (fr != 0) && !e.inv;
    e.rup = up && !e.inv;
    if (e.inv)   e.res = 32'h8000_0000;
    else if (s)  e.res = 32'(64'd0 - rnd);
    else         e.res = rnd[31:0];
    e.tie = (md == 2'b00) && (fr == 7'h40);
    e.sgn = s;
    return e;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference comparison at every falling edge
  logic        hold_v = 1'b0;
  logic [34:0] hold_d;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (hold_v) begin
        chk("R7 valid held", {31'd0, out_valid}, 32'd1);
        chk("R7 data held", {28'd0, out_invalid, out_inexact, out_rndup, 1'b0} ^ {3'd0, hold_d[34:32] ^ {out_invalid, out_inexact, out_rndup}, 26'd0}, {28'd0, out_invalid, out_inexact, out_rndup, 1'b0});
        chk("R7 result held", out_int, hold_d[31:0]);
      end
      hold_v = out_valid && !out_ready;
      hold_d = {out_invalid, out_inexact, out_rndup, out_int};
      if (out_valid && !out_ready)
        chk("R7 in_ready low", {31'd0, in_ready}, 32'd0);
      if (out_valid && out_ready) begin
        if (q.size() == 0) begin
          chk("R8 unexpected output", 32'd1, 32'd0);
        end else begin
          exp_t e;
          string tg;
          e = q.pop_front();
          if (e.inv)      tg = "R3 result";
          else if (e.tie) tg = "R2 result";
          else if (e.sgn) tg = "R4 result";
          else            tg = "R1 result";
          chk(tg, out_int, e.res);
          chk("R3 invalid", {31'd0, out_invalid}, {31'd0, e.inv});
          chk("R5 inexact", {31'd0, out_inexact}, {31'd0, e.inx});
          chk("R6 rounded-up", {31'd0, out_rndup}, {31'd0, e.rup});
        end
      end
      if (in_valid && in_ready) q.push_back(model(in_sign, in_mag, in_mode));
    end
  end

  // back-pressure generator
  always @(posedge clk) begin
    #1;
    if (bp_on) out_ready <= ($urandom % 3) != 0;
    else       out_ready <= 1'b1;
  end

  task automatic send(input logic s, input logic [63:0] m, input logic [1:0] md);
    in_sign = s; in_mag = m; in_mode = md; in_valid = 1'b1;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8 reset out_valid", {31'd0, out_valid}, 32'd0);
    chk("R8 reset in_ready", {31'd0, in_ready}, 32'd1);
    @(posedge clk); #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // latency: accept at next edge, valid seen after it, gone one cycle later
    in_sign = 1'b0; in_mag = 64'h1C0; in_mode = 2'b00; in_valid = 1'b1;
    @(posedge clk); #1 in_valid = 1'b0;
    @(negedge clk);
    chk("R8 out_valid next cycle", {31'd0, out_valid}, 32'd1);
    @(negedge clk);
    chk("R8 out_valid drops", {31'd0, out_valid}, 32'd0);

    // directed corner cases
    send(1'b0, 64'h140, 2'b00);                 // +2.5 nearest -> 2 (R2)
    send(1'b0, 64'h1C0, 2'b00);                 // +3.5 nearest -> 4 (R2)
    send(1'b1, 64'h140, 2'b00);                 // -2.5 nearest -> -2 (R2)
    send(1'b0, 64'h141, 2'b00);                 // just over half (R2)
    send(1'b0, 64'h0A0, 2'b10);                 // +1.25 up -> 2 (R1)
    send(1'b0, 64'h0A0, 2'b01);                 // +1.25 down -> 1 (R1)
    send(1'b0, 64'h0A0, 2'b11);                 // +1.25 zero -> 1 (R1)
    send(1'b1, 64'h0A0, 2'b01);                 // -1.25 down -> -2 (R1)
    send(1'b1, 64'h0A0, 2'b10);                 // -1.25 up -> -1 (R1)
    send(1'b1, 64'h0A0, 2'b11);                 // -1.25 zero -> -1 (R1)
    send(1'b0, 64'd5 << 7, 2'b00);              // exact (R5)
    send(1'b1, 64'd0, 2'b01);                   // negative zero (R4)
    send(1'b1, 64'h01, 2'b00);                  // tiny negative -> 0 (R4)
    send(1'b0, (64'h7FFF_FFFF << 7) | 64'h7F, 2'b00); // carry overflow (R3)
    send(1'b0, (64'h7FFF_FFFF << 7) | 64'h3F, 2'b00); // max positive (R5)
    send(1'b0, (64'h7FFF_FFFF << 7) | 64'h01, 2'b10); // up overflows (R3)
    send(1'b1, 64'h8000_0000 << 7, 2'b00);     // exactly -2^31 legal (R4)
    send(1'b1, (64'h7FFF_FFFF << 7) | 64'h01, 2'b01); // pushed to -2^31 (R4, R6)
    send(1'b1, (64'h8000_0000 << 7) | 64'h01, 2'b01); // below -2^31 (R3)
    send(1'b1, (64'h8000_0000 << 7) | 64'h01, 2'b10); // truncates to -2^31 (R4)
    send(1'b0, 64'h8000_0000 << 7, 2'b11);     // +2^31 invalid (R3)
    send(1'b0, 64'h1 << 62, 2'b00);             // huge (R3)
    send(1'b1, 64'h7FFF_FFFF_FFFF_FFFF, 2'b11); // huge negative (R3)

    // random with back-pressure
    bp_on = 1'b1;
    for (int i = 0; i < 3000; i++) begin
      logic [63:0] m;
      int w;
      m = {$urandom, $urandom};
      w = $urandom % 5;
      case (w)
        0: m = m & 64'h3FFF;
        1: m = m & 64'h7F_FFFF_FFFF;
        2: m = (m & 64'h7F) | ((64'h7FFF_FFFF + ($urandom % 3)) << 7);
        3: m = m & 64'hFF_FFFF_FFFF;
        default: m[63] = 1'b0;
      endcase
      send($urandom % 2, m, 2'($urandom % 4));
    end
    bp_on = 1'b0;
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk("R8 all results drained", q.size(), 32'd0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule